// File: doc/BRIEF.md
# Slow-Domain Parameter Write Synchronizer

This block moves a per-channel setting from a fast bus clock into an independent, much slower clock domain. Each channel keeps its setting in a bus-side register. Once a write is accepted, the block raises that channel's busy flag. It then sends the value across with a toggle handshake. The request toggle passes through a two-flop synchronizer into the slow domain. The slow domain takes the value and returns an acknowledge toggle through a second synchronizer. The busy flag drops when the acknowledge matches the request.

A write made while the flag is set is thrown away, not queued, so the bus-side register stays constant for the whole crossing. A rising edge of a channel's mode enable starts a transfer of the value already held, exactly as a write would. This means the flag also comes up when the mode is switched on with no write at all. The two channels run independently. Each busy flag has a fixed bit in a shared status word, and every other bit of that word reads 0.

Top module: `lss_write_sync`

## Requirements
- R1: After reset, every bit of `status_word` is 0 and every channel's `slow_val` field is 0.
- R2: A write strobe on a channel whose busy flag is 0 is accepted, and the busy flag reads 1 after the next `bus_clk` rising edge. This also holds for a write made in the first cycle after the flag clears.
- R3: Once a transfer is accepted, the channel's `slow_val` field takes the accepted value, and only after that does the busy flag return to 0. The flag clears within 40 bus cycles when the bus clock runs about seven times faster than the slow clock.
- R4: A write strobe on a channel whose busy flag is 1 is ignored. Neither that transfer's result nor any later re-transfer of the held value carries the ignored data.
- R5: A 0-to-1 change of `hold_en[c]` while channel c is idle sets its busy flag and re-transfers the held value. Keeping `hold_en[c]` high starts no further transfer.
- R6: The channels are independent. A transfer on one channel changes neither the busy flag nor the `slow_val` field of the other.
- R7: The busy flag of channel c sits at bit 16*c+15 of `status_word`, so channel 0 uses bit 15 and channel 1 uses bit 31. All other bits read 0.
- R8: A `slow_val` field changes only while its channel has a transfer pending, and it holds steady otherwise.
- R9: A write strobe and an enable rise in the same idle cycle start a single transfer, and that transfer carries the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| slow_clk | input | 1 | Slow, independent clock |
| slow_rst_n | input | 1 | Active-low reset, slow domain |
| hold_en | input | NCH | Per-channel mode enable; a rising edge starts a transfer |
| wr_en | input | NCH | Per-channel write strobe, one bus cycle |
| wr_data | input | DW | Write data shared by all channels |
| status_word | output | 16*NCH | Busy flag of channel c at bit 16*c+15, all other bits 0 |
| slow_val | output | NCH*DW | Values held in the slow domain, channel c at bits c*DW +: DW |

## Verification
The busy flag is due one bus edge after an accepted strobe or enable rise. The bench drives inputs on the falling edge and reads the flag on the next falling edge. The slow-domain value and the clearing of the flag are due after about three slow periods plus two bus cycles, and this timing depends on the phase between the two clocks. For these results the bench polls on each falling edge with a cycle bound, and it checks the value only once the flag has dropped. Ignored writes and the absence of retriggering are checked after the fact, through the value a later transfer delivers or through a flag that stays low over a long idle window.

// File: rtl/lss_pkg.sv
package lss_pkg;
    localparam int STATUS_STRIDE = 16;
    localparam int BUSY_OFFSET   = 15;

    function automatic int busy_pos(input int ch);
        return ch * STATUS_STRIDE + BUSY_OFFSET;
    endfunction
endpackage

// File: rtl/lss_sync.sv
module lss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/lss_bus_chan.sv
module lss_bus_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ack_sync,
    output logic          req,
    output logic          busy,
    output logic [DW-1:0] held
);
    typedef struct packed {
        logic [DW-1:0] held;
        logic          req;
        logic          en_prev;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic    en_rise;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = mode_en;
        busy         = st_q.req ^ ack_sync;
        en_rise      = mode_en & ~st_q.en_prev;
        if (!busy) begin
            if (wr_en) begin
                st_d.held = wr_data;
                st_d.req  = ~st_q.req;
            end else if (en_rise) begin
                st_d.req  = ~st_q.req;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req  = st_q.req;
    assign held = st_q.held;
endmodule

// File: rtl/lss_slow_chan.sv
module lss_slow_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_sync,
    input  logic [DW-1:0] held,
    output logic          ack,
    output logic          pend,
    output logic [DW-1:0] val
);
    typedef struct packed {
        logic [DW-1:0] val;
        logic          ack;
    } slow_st_t;

    slow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pend = req_sync ^ st_q.ack;
        if (pend) begin
            st_d.val = held;
            st_d.ack = req_sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack = st_q.ack;
    assign val = st_q.val;
endmodule

// File: rtl/lss_write_sync.sv
module lss_write_sync
    import lss_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          bus_clk,
    input  logic                          bus_rst_n,
    input  logic                          slow_clk,
    input  logic                          slow_rst_n,
    input  logic [NCH-1:0]                hold_en,
    input  logic [NCH-1:0]                wr_en,
    input  logic [DW-1:0]                 wr_data,
    output logic [NCH*STATUS_STRIDE-1:0]  status_word,
    output logic [NCH*DW-1:0]             slow_val
);
    localparam int SW = NCH * STATUS_STRIDE;

    logic [NCH-1:0]    busy_vec, pend_vec;
    logic [NCH*DW-1:0] held_vec;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic req_t, req_s, ack_t, ack_s;

        lss_bus_chan #(.DW(DW)) u_bus (
            .clk     (bus_clk),
            .rst_n   (bus_rst_n),
            .mode_en (hold_en[c]),
            .wr_en   (wr_en[c]),
            .wr_data (wr_data),
            .ack_sync(ack_s),
            .req     (req_t),
            .busy    (busy_vec[c]),
            .held    (held_vec[c*DW +: DW])
        );

        lss_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
            .clk  (slow_clk),
            .rst_n(slow_rst_n),
            .d    (req_t),
            .q    (req_s)
        );

        lss_slow_chan #(.DW(DW)) u_slow (
            .clk     (slow_clk),
            .rst_n   (slow_rst_n),
            .req_sync(req_s),
            .held    (held_vec[c*DW +: DW]),
            .ack     (ack_t),
            .pend    (pend_vec[c]),
            .val     (slow_val[c*DW +: DW])
        );

        lss_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
            .clk  (bus_clk),
            .rst_n(bus_rst_n),
            .d    (ack_t),
            .q    (ack_s)
        );
    end

    always_comb begin
        status_word = '0;
        for (int c = 0; c < NCH; c++) begin
            status_word[busy_pos(c)] = busy_vec[c];
        end
    end
endmodule

// File: rtl/lss_write_sync_chk.sv
module lss_write_sync_chk
    import lss_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int DW       = 8,
    parameter int SW       = 32,
    parameter int MAX_BUSY = 256
) (
    input logic              bus_clk,
    input logic              bus_rst_n,
    input logic              slow_clk,
    input logic              slow_rst_n,
    input logic [NCH-1:0]    hold_en,
    input logic [NCH-1:0]    wr_en,
    input logic [SW-1:0]     status_word,
    input logic [NCH-1:0]    busy_vec,
    input logic [NCH-1:0]    pend_vec,
    input logic [NCH*DW-1:0] held_vec,
    input logic [NCH*DW-1:0] slow_val
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic [15:0] cnt_q;

        always_ff @(posedge bus_clk or negedge bus_rst_n) begin
            if (!bus_rst_n)       cnt_q <= '0;
            else if (busy_vec[c]) cnt_q <= cnt_q + 16'd1;
            else                  cnt_q <= '0;
        end

        a_r2_write_sets_busy: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            (wr_en[c] && !busy_vec[c]) |=> busy_vec[c]);

        a_r3_busy_bounded: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            cnt_q < 16'(MAX_BUSY));

        a_r3_value_before_clear: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            $fell(busy_vec[c]) |-> (slow_val[c*DW +: DW] == held_vec[c*DW +: DW]));

        a_r4_held_frozen: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            busy_vec[c] |=> $stable(held_vec[c*DW +: DW]));

        a_r5_rise_sets_busy: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            ($rose(hold_en[c]) && !busy_vec[c]) |=> busy_vec[c]);

        a_r7_flag_cause: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            $rose(status_word[busy_pos(c)]) |-> $past(wr_en[c] || hold_en[c]));

        a_r8_slow_moves_on_pend: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
            (slow_val[c*DW +: DW] != $past(slow_val[c*DW +: DW])) |-> $past(pend_vec[c]));
    end
endmodule

bind lss_write_sync lss_write_sync_chk #(.NCH(NCH), .DW(DW), .SW(SW)) u_chk (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .slow_clk   (slow_clk),
    .slow_rst_n (slow_rst_n),
    .hold_en    (hold_en),
    .wr_en      (wr_en),
    .status_word(status_word),
    .busy_vec   (busy_vec),
    .pend_vec   (pend_vec),
    .held_vec   (held_vec),
    .slow_val   (slow_val)
);

// File: tb/lss_write_sync_tb.sv
module lss_write_sync_tb;
    localparam int NCH = 2;
    localparam int DW  = 8;
    localparam int SW  = 32;

    logic bus_clk = 1'b0, slow_clk = 1'b0;
    logic bus_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic [NCH-1:0] hold_en = '0, wr_en = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [SW-1:0]  status_word;
    logic [NCH*DW-1:0] slow_val;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 bus_clk  = ~bus_clk;
    always #73 slow_clk = ~slow_clk;

    lss_write_sync #(.NCH(NCH), .DW(DW)) u_dut (
        .bus_clk    (bus_clk),
        .bus_rst_n  (bus_rst_n),
        .slow_clk   (slow_clk),
        .slow_rst_n (slow_rst_n),
        .hold_en    (hold_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .status_word(status_word),
        .slow_val   (slow_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    function automatic logic [1:0] busy_now();
        return {status_word[31], status_word[15]};
    endfunction

    function automatic logic [7:0] sv(input int c);
        return slow_val[c*DW +: DW];
    endfunction

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy_now() != 2'b00 && cyc < 200) begin
            @(negedge bus_clk);
            cyc++;
        end
    endtask

    task automatic pulse_write(input logic [1:0] ch, input logic [7:0] d);
        wr_en = ch; wr_data = d;
        tick(1);
        wr_en = '0;
    endtask

    task automatic t_reset();
        chk("R1 status after reset", status_word, 32'h0);
        chk("R1 slow_val after reset", 32'(slow_val), 32'h0);
    endtask

    task automatic t_single_write();
        int cyc;
        pulse_write(2'b01, 8'h5A);
        chk("R2/R7 ch0 busy at bit 15", status_word, 32'h0000_8000);
        wait_idle(cyc);
        chk("R3 busy clear bound", 32'(cyc <= 40), 32'd1);
        chk("R3 ch0 slow value", 32'(sv(0)), 32'h5A);
        chk("R6 ch1 untouched", 32'(sv(1)), 32'h0);
    endtask

    task automatic t_ignored_write();
        int cyc;
        pulse_write(2'b10, 8'h11);
        chk("R2/R7 ch1 busy at bit 31", status_word, 32'h8000_0000);
        pulse_write(2'b10, 8'h22);
        wait_idle(cyc);
        chk("R4 write during busy ignored", 32'(sv(1)), 32'h11);
        hold_en[1] = 1'b1;
        tick(1);
        chk("R5 enable rise sets busy", status_word, 32'h8000_0000);
        wait_idle(cyc);
        chk("R4 re-transfer carries held value", 32'(sv(1)), 32'h11);
        tick(60);
        chk("R5 level enable no retrigger", status_word, 32'h0);
        hold_en[1] = 1'b0;
        tick(1);
    endtask

    task automatic t_write_and_rise();
        int cyc;
        hold_en[0] = 1'b1;
        pulse_write(2'b01, 8'h77);
        chk("R9 busy on write+rise", status_word, 32'h0000_8000);
        wait_idle(cyc);
        chk("R9 written data wins", 32'(sv(0)), 32'h77);
        tick(60);
        chk("R9 single transfer", status_word, 32'h0);
        hold_en[0] = 1'b0;
        tick(1);
    endtask

    task automatic t_both_channels();
        int cyc;
        pulse_write(2'b11, 8'hC3);
        chk("R6/R7 both busy bits", status_word, 32'h8000_8000);
        wait_idle(cyc);
        chk("R6 ch0 value", 32'(sv(0)), 32'hC3);
        chk("R6 ch1 value", 32'(sv(1)), 32'hC3);
        pulse_write(2'b01, 8'h3C);
        chk("R6 ch1 flag stays low", 32'(status_word[31]), 32'h0);
        wait_idle(cyc);
        chk("R6 ch1 value kept", 32'(sv(1)), 32'hC3);
        chk("R6 ch0 new value", 32'(sv(0)), 32'h3C);
    endtask

    task automatic t_back_to_back();
        int cyc;
        pulse_write(2'b01, 8'hE1);
        wait_idle(cyc);
        pulse_write(2'b01, 8'h96);
        chk("R2 write right after clear", status_word, 32'h0000_8000);
        wait_idle(cyc);
        chk("R2 second value delivered", 32'(sv(0)), 32'h96);
    endtask

    task automatic t_idle_stable();
        logic [15:0] snap;
        snap = slow_val;
        tick(80);
        chk("R8 slow_val steady when idle", 32'(slow_val), 32'(snap));
        chk("R7 status idle", status_word, 32'h0);
    endtask

    initial begin
        tick(20);
        bus_rst_n = 1'b1;
        slow_rst_n = 1'b1;
        tick(2);
        t_reset();
        t_single_write();
        t_ignored_write();
        t_write_and_rise();
        t_both_channels();
        t_back_to_back();
        t_idle_stable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge bus_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule